// File: doc/BRIEF.md
# Byte-Aliased Register File

This block holds the general and segment registers of a 16-bit processor core. Eight word registers are kept in the general bank. Four of them are data registers: the accumulator, count, data and base registers. The other four are the stack pointer, base pointer, source index and destination index. A separate bank holds the four segment registers. The instruction pointer lives elsewhere, so no select code can reach it.

The general bank has two combinational read ports and one write port. Each port has its own size bit and 3-bit register select. With the size bit high, the select names a whole word register. With the size bit low, the select names one byte of a data register. That byte is not separate storage: it is one half of a data register. A byte write therefore changes exactly one 8-bit lane and leaves the other lane as it was. The segment bank has its own write port and read port, each with a 2-bit select. All storage is cleared by a synchronous reset.

Top module: `byte_alias_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every general and segment register becomes 0000h. Writes have no effect in that cycle.
- R2: When `wr_en` is high and `wr_size`=1 at a rising edge, the register named by `wr_sel` takes `wr_data`. The word code order is 0=accumulator, 1=count, 2=data, 3=base, 4=stack pointer, 5=base pointer, 6=source index, 7=destination index. A word read with the same code returns that value from the next cycle on.
- R3: A byte write (`wr_size`=0) with a code from 0 to 3 loads `wr_data[7:0]` into bits 7:0 of the data register whose word code equals `wr_sel[1:0]`. Bits 15:8 of that register keep their value.
- R4: A byte write with a code from 4 to 7 loads `wr_data[7:0]` into bits 15:8 of the data register whose word code equals `wr_sel[1:0]`. Bits 7:0 of that register keep their value.
- R5: A byte read (`rd_*_size`=0) returns the addressed byte in bits 7:0 and zeros in bits 15:8. It uses the same code mapping as R3 and R4.
- R6: When `wr_en` is low, no general register changes, whatever the other write inputs hold.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the value from before the edge.
- R8: Byte access never reaches the pointer and index registers: byte codes 4 to 7 select high data bytes, so a byte write leaves the stack pointer, base pointer, source index and destination index unchanged.
- R9: The segment bank is addressed with a 2-bit code: 0=extra, 1=code, 2=stack, 3=data. With `seg_wr_en` high, `seg_wr_data` is written there at the edge. Segment writes leave general registers unchanged, and general writes leave segment registers unchanged.
- R10: Read ports A and B work independently of each other. Each applies its own size and select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | General write enable |
| wr_size | input | 1 | 1 = word write, 0 = byte write |
| wr_sel | input | 3 | Word or byte register code for the write |
| wr_data | input | 16 | Write value (bits 7:0 used for byte writes) |
| rd_a_size | input | 1 | Port A size: 1 = word, 0 = byte |
| rd_a_sel | input | 3 | Port A register code |
| rd_a_data | output | 16 | Port A read value |
| rd_b_size | input | 1 | Port B size: 1 = word, 0 = byte |
| rd_b_sel | input | 3 | Port B register code |
| rd_b_data | output | 16 | Port B read value |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_sel | input | 2 | Segment write code |
| seg_wr_data | input | 16 | Segment write value |
| seg_rd_sel | input | 2 | Segment read code |
| seg_rd_data | output | 16 | Segment read value |

## Verification
Two things can fall in the same cycle: a write to a register and a combinational read of that same register. A byte write can also happen while a read views the other lane or the whole word. The random stimulus often points read port A at the write target. The bench checks the read value before the edge against the old model contents, and checks it again after the edge against the updated contents. In the update, only the addressed lane of the model changes.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int WORD_W_DEF = 16;
  localparam int LANE_W_DEF = 8;
  localparam int N_GPR_DEF  = 8;
  localparam int N_SEG_DEF  = 4;

  typedef enum logic [2:0] {
    W_ACC = 3'd0, W_CNT = 3'd1, W_DAT = 3'd2, W_BAS = 3'd3,
    W_STK = 3'd4, W_BPT = 3'd5, W_SRC = 3'd6, W_DST = 3'd7
  } word_code_e;

  typedef enum logic [1:0] {
    S_EXTRA = 2'd0, S_CODE = 2'd1, S_STACK = 2'd2, S_DATA = 2'd3
  } seg_code_e;
endpackage

// File: rtl/brf_decode.sv
module brf_decode #(
  parameter int N_REG = 8,
  parameter int LANES = 2,
  parameter int SEL_W = $clog2(N_REG)
) (
  input  logic                         we,
  input  logic                         word,
  input  logic [SEL_W-1:0]             sel,
  output logic [N_REG-1:0][LANES-1:0]  lane_we
);
  always_comb begin
    lane_we = '0;
    if (we) begin
      if (word) begin
        lane_we[sel] = '1;
      end else begin
        // upper select bit picks the lane, lower bits pick a data register
        lane_we[sel[SEL_W-2:0]][sel[SEL_W-1]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/brf_bank.sv
module brf_bank #(
  parameter int N_REG  = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [N_REG-1:0][LANES-1:0]              lane_we,
  input  logic [LANES-1:0][LANE_W-1:0]             wr_lane,
  output logic [N_REG-1:0][LANES-1:0][LANE_W-1:0]  q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [N_REG];

    always_ff @(posedge clk) begin
      for (int r = 0; r < N_REG; r++) begin
        if (rst) begin
          mem[r] <= '0;
        end else if (lane_we[r][l]) begin
          mem[r] <= wr_lane[l];
        end
      end
    end

    for (genvar r = 0; r < N_REG; r++) begin : g_out
      assign q[r][l] = mem[r];
    end
  end
endmodule

// File: rtl/brf_read_port.sv
module brf_read_port #(
  parameter int N_REG  = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int SEL_W  = $clog2(N_REG)
) (
  input  logic [N_REG-1:0][LANES-1:0][LANE_W-1:0] regs,
  input  logic                                    word,
  input  logic [SEL_W-1:0]                        sel,
  output logic [LANES*LANE_W-1:0]                 data
);
  always_comb begin
    data = '0;
    if (word) begin
      data = regs[sel];
    end else begin
      data[LANE_W-1:0] = regs[sel[SEL_W-2:0]][sel[SEL_W-1]];
    end
  end
endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile
  import brf_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int LANE_W = LANE_W_DEF,
  parameter int N_GPR  = N_GPR_DEF,
  parameter int N_SEG  = N_SEG_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_size,
  input  logic [$clog2(N_GPR)-1:0] wr_sel,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     rd_a_size,
  input  logic [$clog2(N_GPR)-1:0] rd_a_sel,
  output logic [WORD_W-1:0]        rd_a_data,
  input  logic                     rd_b_size,
  input  logic [$clog2(N_GPR)-1:0] rd_b_sel,
  output logic [WORD_W-1:0]        rd_b_data,
  input  logic                     seg_wr_en,
  input  logic [$clog2(N_SEG)-1:0] seg_wr_sel,
  input  logic [WORD_W-1:0]        seg_wr_data,
  input  logic [$clog2(N_SEG)-1:0] seg_rd_sel,
  output logic [WORD_W-1:0]        seg_rd_data
);
  localparam int LANES     = WORD_W / LANE_W;
  localparam int SEL_W     = $clog2(N_GPR);
  localparam int SEG_SEL_W = $clog2(N_SEG);

  logic [N_GPR-1:0][LANES-1:0]              gpr_we;
  logic [N_SEG-1:0][LANES-1:0]              seg_we;
  logic [LANES-1:0][LANE_W-1:0]             gpr_lane;
  logic [LANES-1:0][LANE_W-1:0]             seg_lane;
  logic [N_GPR-1:0][LANES-1:0][LANE_W-1:0]  gpr_q;
  logic [N_SEG-1:0][LANES-1:0][LANE_W-1:0]  seg_q;

  // byte writes steer the low input byte onto whichever lane is enabled
  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    assign gpr_lane[l] = wr_size ? wr_data[l*LANE_W +: LANE_W] : wr_data[LANE_W-1:0];
    assign seg_lane[l] = seg_wr_data[l*LANE_W +: LANE_W];
  end

  brf_decode #(.N_REG(N_GPR), .LANES(LANES), .SEL_W(SEL_W)) u_gpr_dec (
    .we(wr_en), .word(wr_size), .sel(wr_sel), .lane_we(gpr_we)
  );

  brf_decode #(.N_REG(N_SEG), .LANES(LANES), .SEL_W(SEG_SEL_W)) u_seg_dec (
    .we(seg_wr_en), .word(1'b1), .sel(seg_wr_sel), .lane_we(seg_we)
  );

  brf_bank #(.N_REG(N_GPR), .LANES(LANES), .LANE_W(LANE_W)) u_gpr_bank (
    .clk(clk), .rst(rst), .lane_we(gpr_we), .wr_lane(gpr_lane), .q(gpr_q)
  );

  brf_bank #(.N_REG(N_SEG), .LANES(LANES), .LANE_W(LANE_W)) u_seg_bank (
    .clk(clk), .rst(rst), .lane_we(seg_we), .wr_lane(seg_lane), .q(seg_q)
  );

  brf_read_port #(.N_REG(N_GPR), .LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_rd_a (
    .regs(gpr_q), .word(rd_a_size), .sel(rd_a_sel), .data(rd_a_data)
  );

  brf_read_port #(.N_REG(N_GPR), .LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_rd_b (
    .regs(gpr_q), .word(rd_b_size), .sel(rd_b_sel), .data(rd_b_data)
  );

  assign seg_rd_data = seg_q[seg_rd_sel];
endmodule

// File: rtl/brf_checker.sv
module brf_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_size,
  input logic [2:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic        rd_a_size,
  input logic [2:0]  rd_a_sel,
  input logic [15:0] rd_a_data,
  input logic        rd_b_size,
  input logic [15:0] rd_b_data,
  input logic        seg_wr_en,
  input logic [1:0]  seg_rd_sel,
  input logic [15:0] seg_rd_data
);
  AST_CLEAR_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == 16'h0 && rd_b_data == 16'h0 && seg_rd_data == 16'h0)); // R1

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size) |=>
      (!(rd_a_size && rd_a_sel == $past(wr_sel)) || rd_a_data == $past(wr_data))); // R2

  AST_LOW_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_size && !wr_sel[2] && rd_a_size && rd_a_sel == {1'b0, wr_sel[1:0]}) |=>
      (!($stable(rd_a_sel) && $stable(rd_a_size)) ||
       rd_a_data == {$past(rd_a_data[15:8]), $past(wr_data[7:0])})); // R3

  AST_HIGH_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_size && wr_sel[2] && rd_a_size && rd_a_sel == {1'b0, wr_sel[1:0]}) |=>
      (!($stable(rd_a_sel) && $stable(rd_a_size)) ||
       rd_a_data == {$past(wr_data[7:0]), $past(rd_a_data[7:0])})); // R4

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (!rd_a_size || !rd_b_size) |->
      ((rd_a_size || rd_a_data[15:8] == 8'h0) && (rd_b_size || rd_b_data[15:8] == 8'h0))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!($stable(rd_a_sel) && $stable(rd_a_size)) || $stable(rd_a_data))); // R6

  AST_SEG_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !seg_wr_en |=> (!$stable(seg_rd_sel) || $stable(seg_rd_data))); // R9
endmodule

bind byte_alias_regfile brf_checker u_brf_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_a_size(rd_a_size), .rd_a_sel(rd_a_sel),
  .rd_a_data(rd_a_data), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
  .seg_wr_en(seg_wr_en), .seg_rd_sel(seg_rd_sel), .seg_rd_data(seg_rd_data)
);

// File: tb/tb_byte_alias_regfile.sv
module tb_byte_alias_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_size = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        rd_a_size = 1'b1, rd_b_size = 1'b1;
  logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
  logic [15:0] rd_a_data, rd_b_data;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0, seg_rd_sel = '0;
  logic [15:0] seg_wr_data = '0, seg_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_gpr [8];
  logic [15:0] m_seg [4];

  always #10 clk = ~clk;

  byte_alias_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_a_size(rd_a_size), .rd_a_sel(rd_a_sel),
    .rd_a_data(rd_a_data), .rd_b_size(rd_b_size), .rd_b_sel(rd_b_sel),
    .rd_b_data(rd_b_data), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .seg_rd_sel(seg_rd_sel), .seg_rd_data(seg_rd_data)
  );

  function automatic logic [15:0] exp_rd(input logic sz, input logic [2:0] s);
    if (sz) return m_gpr[s];
    if (s[2]) return {8'h00, m_gpr[s[1:0]][15:8]};
    return {8'h00, m_gpr[s[1:0]][7:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek_a(input string tag, input logic sz, input logic [2:0] s);
    rd_a_size = sz; rd_a_sel = s; #1;
    chk(tag, rd_a_data, exp_rd(sz, s));
  endtask

  task automatic peek_b(input string tag, input logic sz, input logic [2:0] s);
    rd_b_size = sz; rd_b_sel = s; #1;
    chk(tag, rd_b_data, exp_rd(sz, s));
  endtask

  task automatic peek_seg(input string tag, input logic [1:0] s);
    seg_rd_sel = s; #1;
    chk(tag, seg_rd_data, m_seg[s]);
  endtask

  // one clock: drive at falling edge, update model at rising edge, idle again
  task automatic tick(input logic r, input logic we, input logic sz, input logic [2:0] s,
                      input logic [15:0] d, input logic swe, input logic [1:0] ss,
                      input logic [15:0] sd);
    @(negedge clk);
    rst = r; wr_en = we; wr_size = sz; wr_sel = s; wr_data = d;
    seg_wr_en = swe; seg_wr_sel = ss; seg_wr_data = sd;
    @(posedge clk);
    if (r) begin
      foreach (m_gpr[i]) m_gpr[i] = '0;
      foreach (m_seg[i]) m_seg[i] = '0;
    end else begin
      if (we) begin
        if (sz) m_gpr[s] = d;
        else if (s[2]) m_gpr[s[1:0]][15:8] = d[7:0];
        else m_gpr[s[1:0]][7:0] = d[7:0];
      end
      if (swe) m_seg[ss] = sd;
    end
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; seg_wr_en = 1'b0;
    wr_data = 16'hDEAD; wr_sel = 3'd7; seg_wr_data = 16'hBEEF;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] sp_before;
    foreach (m_gpr[i]) m_gpr[i] = 16'hxxxx;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    tick(1'b1, 1'b0, 1'b1, 3'd0, 16'h0, 1'b0, 2'd0, 16'h0);

    // R1: everything zero after reset
    for (int i = 0; i < 8; i++) peek_a("R1", 1'b1, 3'(i));
    for (int i = 0; i < 4; i++) peek_seg("R1", 2'(i));

    // R2 / R10: word writes to every code, read back on both ports
    for (int i = 0; i < 8; i++)
      tick(1'b0, 1'b1, 1'b1, 3'(i), 16'(16'h1111 * (i + 1) + 16'h0102), 1'b0, 2'd0, 16'h0);
    for (int i = 0; i < 8; i++) begin
      peek_a("R2", 1'b1, 3'(i));
      peek_b("R10", 1'b1, 3'(7 - i));
    end

    // R3: low byte of count register, high byte must survive
    tick(1'b0, 1'b1, 1'b0, 3'd1, 16'h77A5, 1'b0, 2'd0, 16'h0);
    peek_a("R3", 1'b1, 3'd1);
    chk("R3", rd_a_data[15:8], {8'h00, m_gpr[1][15:8]} >> 0 & 16'h00FF);

    // R4: high byte of base register, low byte must survive
    tick(1'b0, 1'b1, 1'b0, 3'd7, 16'h993C, 1'b0, 2'd0, 16'h0);
    peek_a("R4", 1'b1, 3'd3);

    // R5: byte reads zero-extended on both ports
    peek_a("R5", 1'b0, 3'd5);
    peek_b("R5", 1'b0, 3'd1);

    // R8: high-byte code 4 targets accumulator, stack pointer untouched
    rd_b_size = 1'b1; rd_b_sel = 3'd4; #1;
    sp_before = rd_b_data;
    tick(1'b0, 1'b1, 1'b0, 3'd4, 16'h00E1, 1'b0, 2'd0, 16'h0);
    rd_b_size = 1'b1; rd_b_sel = 3'd4; #1;
    chk("R8", rd_b_data, sp_before);
    peek_a("R8", 1'b1, 3'd0);

    // R6: disabled write with live data and select
    tick(1'b0, 1'b0, 1'b1, 3'd2, 16'hFFFF, 1'b0, 2'd0, 16'h0);
    peek_a("R6", 1'b1, 3'd2);

    // R9: segment writes and cross-bank isolation
    for (int i = 0; i < 4; i++)
      tick(1'b0, 1'b0, 1'b1, 3'd0, 16'h0, 1'b1, 2'(i), 16'(16'hA000 + i * 16'h0111));
    for (int i = 0; i < 4; i++) peek_seg("R9", 2'(i));
    for (int i = 0; i < 8; i++) peek_a("R9", 1'b1, 3'(i));
    tick(1'b0, 1'b1, 1'b1, 3'd6, 16'h5A5A, 1'b0, 2'd0, 16'h0);
    for (int i = 0; i < 4; i++) peek_seg("R9", 2'(i));

    // R7: same-cycle read of the write target returns the old value
    @(negedge clk);
    wr_en = 1'b1; wr_size = 1'b1; wr_sel = 3'd5; wr_data = 16'h1234;
    rd_a_size = 1'b1; rd_a_sel = 3'd5; #2;
    chk("R7", rd_a_data, m_gpr[5]);
    @(posedge clk); m_gpr[5] = 16'h1234;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R7", rd_a_data, 16'h1234);

    // random mix: pre-edge reads against model (old contents)
    for (int n = 0; n < 600; n++) begin
      logic we, sz, swe, asz;
      logic [2:0] s, as_;
      logic [15:0] d;
      we = 1'($urandom); sz = 1'($urandom); s = 3'($urandom); d = 16'($urandom);
      swe = 1'($urandom);
      asz = 1'($urandom);
      as_ = (($urandom % 2) == 0) ? s : 3'($urandom);
      @(negedge clk);
      wr_en = we; wr_size = sz; wr_sel = s; wr_data = d;
      seg_wr_en = swe; seg_wr_sel = 2'($urandom); seg_wr_data = 16'($urandom);
      rd_a_size = asz; rd_a_sel = as_;
      rd_b_size = 1'($urandom); rd_b_sel = 3'($urandom);
      seg_rd_sel = 2'($urandom);
      #2;
      chk(we ? "R7" : (asz ? "R2" : "R5"), rd_a_data, exp_rd(asz, as_));
      chk("R10", rd_b_data, exp_rd(rd_b_size, rd_b_sel));
      chk("R9", seg_rd_data, m_seg[seg_rd_sel]);
      @(posedge clk);
      if (we) begin
        if (sz) m_gpr[s] = d;
        else if (s[2]) m_gpr[s[1:0]][15:8] = d[7:0];
        else m_gpr[s[1:0]][7:0] = d[7:0];
      end
      if (swe) m_seg[seg_wr_sel] = seg_wr_data;
    end
    @(negedge clk); wr_en = 1'b0; seg_wr_en = 1'b0;
    for (int i = 0; i < 8; i++) peek_a(i < 4 ? "R3" : "R8", 1'b1, 3'(i));

    // R1: reset wins over a simultaneous write
    tick(1'b1, 1'b1, 1'b1, 3'd0, 16'hFFFF, 1'b1, 2'd1, 16'hFFFF);
    for (int i = 0; i < 8; i++) peek_b("R1", 1'b1, 3'(i));
    for (int i = 0; i < 4; i++) peek_seg("R1", 2'(i));

    finish_run();
  end
endmodule